// File: doc/BRIEF.md
# Internal Data Memory Address Steering Unit

This block is the internal data-space access unit of a small 8-bit controller core. It holds 256 bytes of scratch RAM and a stack pointer. Each access request it receives is routed either to the RAM or to an external special-function-register (SFR) bus. Each request carries an address, an access mode, a write flag and write data.

The lower half of the address space (00h to 7Fh) is always RAM. The upper half (80h to FFh) is shared by two separate physical spaces, and only the access mode picks between them:

- A direct access in the upper half goes out on the SFR bus.
- An indirect access in the upper half reaches the upper RAM bytes.
- Push and pop count as indirect accesses, so the stack can grow into upper RAM.

Read results are registered and appear one clock after the request. The core can observe the current stack pointer value at all times.

Top module: `dmem_steer`

## Requirements
- R1: After reset the stack pointer reads 07h, `rd_valid` is 0, `rd_data` is 00h and both SFR strobes are 0.
- R2: Any access whose address is in 00h..7Fh reaches RAM in both direct (`req_mode`=0) and indirect (`req_mode`=1) mode. A byte written in one mode reads back in the other, and no SFR strobe is raised.
- R3: A direct write (`req_we`=1) to an address in 80h..FFh raises `sfr_wr` for exactly that cycle, with `sfr_addr` and `sfr_wdata` equal to the request. The RAM byte at that address is left unchanged.
- R4: A direct read to an address in 80h..FFh raises `sfr_rd` for exactly that cycle. On the next clock `rd_data` equals the `sfr_rdata` value presented in the request cycle.
- R5: An indirect access to an address in 80h..FFh reads or writes the upper RAM byte at that address and raises no SFR strobe.
- R6: A push (`req_mode`=2) first increments the stack pointer, then writes `req_wdata` to RAM at the new pointer value. `req_addr` and `req_we` are ignored.
- R7: A pop (`req_mode`=3) returns the RAM byte at the current stack pointer on the next clock, then decrements the pointer. `req_addr` and `req_we` are ignored.
- R8: The stack pointer wraps modulo 256: a push at FFh writes address 00h, and a pop at 00h leaves the pointer at FFh.
- R9: `rd_valid` is high in exactly the cycle after each read request (a direct or indirect read, or a pop), and low otherwise. While it is low, `rd_data` keeps its last value.
- R10: While `req_valid` is 0, no strobe is raised, the stack pointer holds and the RAM is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read (direct/indirect only) |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 push, 3 pop |
| req_addr | input | 8 | Access address (direct/indirect only) |
| req_wdata | input | 8 | Write data for writes and pushes |
| sfr_rdata | input | 8 | Read data returned by the SFR bus in the strobe cycle |
| sfr_rd | output | 1 | One-cycle SFR read strobe |
| sfr_wr | output | 1 | One-cycle SFR write strobe |
| sfr_addr | output | 8 | SFR address, valid with a strobe |
| sfr_wdata | output | 8 | SFR write data, valid with `sfr_wr` |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds a new result this cycle |
| sp_out | output | 8 | Current stack pointer |

## Verification
On every cycle, the assertions check:

- the stack pointer step for push, pop and idle;
- the one-cycle read latency and its valid flag;
- the capture of SFR read data;
- that indirect, push and pop accesses never raise an SFR strobe;
- that the SFR address and data match the request.

Only the bench scenarios can show that the two upper-half spaces really are separate. It writes a direct SFR byte and then reads the same address indirectly to find the old RAM byte unchanged. The same holds for the values returned by pops after a chain of pushes and for the modulo-256 wrap of the pointer. The randomized mix of modes and addresses is checked against a bench memory model.

// File: rtl/dmem_pkg.sv
// Package: shared types for the data-memory steering unit.
// Assumes a 2-bit access-mode code fixed by the instruction decoder.
package dmem_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'd0,
        MODE_INDIRECT = 2'd1,
        MODE_PUSH     = 2'd2,
        MODE_POP      = 2'd3
    } acc_mode_t;

    // Routing decision for one request cycle.
    typedef struct packed {
        logic ram_we;   // write the RAM this cycle
        logic ram_re;   // read the RAM this cycle
        logic sfr_we;   // strobe an SFR write
        logic sfr_re;   // strobe an SFR read
        logic sp_inc;   // increment stack pointer
        logic sp_dec;   // decrement stack pointer
        logic at_next;  // RAM address is stack pointer plus one
        logic at_sp;    // RAM address is stack pointer
    } route_t;

endpackage

// File: rtl/dmem_route.sv
// Module: dmem_route
// Decides, from mode, address and write flag, whether a request goes to
// RAM or to the SFR bus, and what it does to the stack pointer.
// Assumes the upper half of the address space is shared by SFRs and RAM.
module dmem_route
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    output route_t            route
);
    logic      upper_half;
    acc_mode_t mode;

    assign mode       = acc_mode_t'(req_mode);
    assign upper_half = req_addr[ADDR_W-1];

    // Purpose: translate one request into routing controls.
    always_comb begin
        route = '0;
        if (req_valid) begin
            unique case (mode)
                MODE_DIRECT: begin
                    if (upper_half) begin
                        route.sfr_we = req_we;
                        route.sfr_re = ~req_we;
                    end else begin
                        route.ram_we = req_we;
                        route.ram_re = ~req_we;
                    end
                end
                MODE_INDIRECT: begin
                    route.ram_we = req_we;
                    route.ram_re = ~req_we;
                end
                MODE_PUSH: begin
                    route.ram_we  = 1'b1;
                    route.sp_inc  = 1'b1;
                    route.at_next = 1'b1;
                end
                MODE_POP: begin
                    route.ram_re = 1'b1;
                    route.sp_dec = 1'b1;
                    route.at_sp  = 1'b1;
                end
                default: route = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmem_sp.sv
// Module: dmem_sp
// Stack pointer register: steps up on push, down on pop, wraps modulo
// 2**ADDR_W. Assumes push and pop never arrive in the same cycle.
module dmem_sp #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  RESET_VAL = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] sp_next
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    assign sp_next = sp_q + ONE;

    // Purpose: hold and step the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= ADDR_W'(RESET_VAL);
        end else if (inc) begin
            sp_q <= sp_next;
        end else if (dec) begin
            sp_q <= sp_q - ONE;
        end
    end
endmodule

// File: rtl/dmem_ram.sv
// Module: dmem_ram
// Scratch RAM, 2**ADDR_W words: synchronous write, asynchronous read.
// Contents are not reset; the user must write before reading.
module dmem_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store a word on a write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dmem_rdport.sv
// Module: dmem_rdport
// Read-return register: captures RAM or SFR read data at the clock after
// a read request and flags it with a one-cycle valid.
// Assumes at most one read source is active per cycle.
module dmem_rdport #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_re,
    input  logic              sfr_re,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] sfr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Purpose: register the selected read source and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= ram_re | sfr_re;
            if (sfr_re) begin
                rd_data <= sfr_rdata;
            end else if (ram_re) begin
                rd_data <= ram_rdata;
            end
        end
    end
endmodule

// File: rtl/dmem_steer.sv
// Module: dmem_steer (top)
// Internal data-space access unit: routes each request to scratch RAM or
// to the SFR bus by mode and address, and runs the stack pointer.
// Assumes one request per cycle and that the SFR bus answers reads
// combinationally in the strobe cycle.
module dmem_steer
    import dmem_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] sfr_rdata,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sp_out
);
    route_t            route;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_next;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata;

    dmem_route #(.ADDR_W(ADDR_W)) u_route (
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_mode  (req_mode),
        .req_addr  (req_addr),
        .route     (route)
    );

    dmem_sp #(.ADDR_W(ADDR_W), .RESET_VAL(SP_RESET)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (route.sp_inc),
        .dec     (route.sp_dec),
        .sp_q    (sp_q),
        .sp_next (sp_next)
    );

    // Purpose: pick the RAM address from the stack pointer or the request.
    always_comb begin
        if (route.at_next) begin
            ram_addr = sp_next;
        end else if (route.at_sp) begin
            ram_addr = sp_q;
        end else begin
            ram_addr = req_addr;
        end
    end

    dmem_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (route.ram_we),
        .addr  (ram_addr),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    dmem_rdport #(.DATA_W(DATA_W)) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_re    (route.ram_re),
        .sfr_re    (route.sfr_re),
        .ram_rdata (ram_rdata),
        .sfr_rdata (sfr_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign sfr_rd    = route.sfr_re;
    assign sfr_wr    = route.sfr_we;
    assign sfr_addr  = req_addr;
    assign sfr_wdata = req_wdata;
    assign sp_out    = sp_q;
endmodule

// File: rtl/dmem_steer_chk.sv
// Module: dmem_steer_chk
// Assertion checker bound to dmem_steer; observes ports only.
module dmem_steer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [1:0]        req_mode,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              sfr_rd,
    input logic              sfr_wr,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sp_out
);
    logic is_read;
    assign is_read = req_valid && ((req_mode == 2'd3) ||
                     (req_mode[1] == 1'b0 && !req_we));

    // R3
    sfr_wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> (sfr_addr == req_addr && sfr_wdata == req_wdata && !sfr_rd));

    // R4
    sfr_rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd |=> (rd_data == $past(sfr_rdata)));

    // R5
    indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 2'd0) |-> (!sfr_rd && !sfr_wr));

    // R6
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd2) |=> (sp_out == $past(sp_out) + 1'b1));

    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd3) |=> (sp_out == $past(sp_out) - 1'b1));

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rd_valid);

    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> (!rd_valid && $stable(rd_data)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(sp_out));

    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!sfr_rd && !sfr_wr));
endmodule

bind dmem_steer dmem_steer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dmem_steer.sv
// Bench for dmem_steer: directed corner cases plus seeded random mix,
// checked against a bench memory/stack model.
module tb_dmem_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_we = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic [7:0] sfr_rdata = 8'h00;
    logic       sfr_rd, sfr_wr, rd_valid;
    logic [7:0] sfr_addr, sfr_wdata, rd_data, sp_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_mem [256];
    logic [7:0] model_sp;
    logic [7:0] last_rd;

    always #10 clk = ~clk;

    dmem_steer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .sfr_rdata(sfr_rdata), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .sp_out(sp_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit goes_sfr(input logic [1:0] m, input logic [7:0] a);
        return (m == 2'd0) && a[7];
    endfunction

    function automatic bit is_rd(input logic [1:0] m, input logic w);
        return (m == 2'd3) || (m[1] == 1'b0 && !w);
    endfunction

    // One request cycle: drive at negedge, check strobes, then results.
    task automatic issue(input string tag, input logic [1:0] m, input logic w,
                         input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] sd);
        logic [7:0] exp_rd;
        bit sfr, rd;
        sfr = goes_sfr(m, a);
        rd  = is_rd(m, w);
        exp_rd = last_rd;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_we = w; req_addr = a;
        req_wdata = d; sfr_rdata = sd;
        #2;
        check({tag, " sfr_wr"}, sfr_wr, sfr && w);
        check({tag, " sfr_rd"}, sfr_rd, sfr && !w);
        if (sfr && w) begin
            check({tag, " sfr_addr"}, sfr_addr, a);
            check({tag, " sfr_wdata"}, sfr_wdata, d);
        end
        // model update
        case (m)
            2'd0, 2'd1: begin
                if (sfr) begin
                    if (!w) exp_rd = sd;
                end else if (w) model_mem[a] = d;
                else exp_rd = model_mem[a];
            end
            2'd2: begin
                model_sp = model_sp + 8'd1;
                model_mem[model_sp] = d;
            end
            default: begin
                exp_rd = model_mem[model_sp];
                model_sp = model_sp - 8'd1;
            end
        endcase
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        check({tag, " rd_valid R9"}, rd_valid, rd);
        check({tag, " rd_data"}, rd_data, exp_rd);
        check({tag, " sp"}, sp_out, model_sp);
        last_rd = exp_rd;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));
        model_sp = 8'h07;
        last_rd = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1 sp", sp_out, 8'h07);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 strobes", {sfr_rd, sfr_wr}, 0);

        // Fill all RAM with indirect writes (R5 for upper half)
        for (int i = 0; i < 256; i++) issue("R5 fill", 2'd1, 1'b1, 8'(i), 8'(i ^ 8'h5A), 8'h00);

        // R2: direct write low, indirect read back and vice versa
        issue("R2 dwr", 2'd0, 1'b1, 8'h12, 8'hC3, 8'h00);
        issue("R2 ird", 2'd1, 1'b0, 8'h12, 8'h00, 8'h00);
        issue("R2 iwr", 2'd1, 1'b1, 8'h7F, 8'h3C, 8'h00);
        issue("R2 drd", 2'd0, 1'b0, 8'h7F, 8'h00, 8'h00);

        // R3: direct SFR write leaves RAM at A0h unchanged
        issue("R3 sfrwr", 2'd0, 1'b1, 8'hA0, 8'hEE, 8'h00);
        issue("R3 ram intact", 2'd1, 1'b0, 8'hA0, 8'h00, 8'h00);

        // R4: direct SFR read returns bus data
        issue("R4 sfrrd", 2'd0, 1'b0, 8'h80, 8'h00, 8'h99);
        issue("R4 sfrrd ff", 2'd0, 1'b0, 8'hFF, 8'h00, 8'h42);

        // R5: indirect upper write/read
        issue("R5 iwr", 2'd1, 1'b1, 8'hA0, 8'h77, 8'h11);
        issue("R5 ird", 2'd1, 1'b0, 8'hA0, 8'h00, 8'h11);

        // R6/R7 push then pop, addr/we ignored
        issue("R6 push", 2'd2, 1'b0, 8'h33, 8'hAB, 8'h00);
        issue("R6 push", 2'd2, 1'b0, 8'h44, 8'hCD, 8'h00);
        issue("R7 pop", 2'd3, 1'b1, 8'h55, 8'h00, 8'h00);
        issue("R7 pop", 2'd3, 1'b1, 8'h66, 8'h00, 8'h00);

        // R10: idle cycles change nothing
        repeat (4) @(negedge clk);
        check("R10 sp hold", sp_out, model_sp);
        check("R10 rd_valid", rd_valid, 0);
        check("R10 strobes", {sfr_rd, sfr_wr}, 0);

        // R8: push up to FFh, then wrap to 00h
        while (model_sp != 8'hFF) issue("R8 climb", 2'd2, 1'b0, 8'h00, model_sp ^ 8'hA5, 8'h00);
        issue("R8 push wrap", 2'd2, 1'b0, 8'h00, 8'h5E, 8'h00);
        check("R8 sp wrap up", sp_out, 8'h00);
        issue("R8 rd 00", 2'd1, 1'b0, 8'h00, 8'h00, 8'h00);
        issue("R8 pop wrap", 2'd3, 1'b0, 8'h00, 8'h00, 8'h00);
        check("R8 sp wrap dn", sp_out, 8'hFF);

        // Random mix
        for (int k = 0; k < 600; k++) begin
            logic [1:0] m;
            m = 2'($urandom);
            issue("R9 rand", m, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule